// File: doc/BRIEF.md
# Two-Bit-Per-Symbol Quaternary Stream Converter

This block sits between a serial bit stream and a four-level (2B1Q) symbol stream and converts in both directions. Every symbol ("quat") carries exactly two bits, held as a sign bit and a magnitude bit. On the transmit side two consecutive bits are gathered into one quat, which is presented for a whole quat period. On the receive side each quat that arrives is split back into two bits. Both sides share one bit-pair phase, so quat boundaries never slip between the two streams.

A free-running divider derives a bit-rate enable from the system clock, and a quat-rate enable on every second bit. A run-time orientation input chooses whether the sign bit or the magnitude bit is the earlier bit of each pair. The choice applies to both directions and is taken up only at a quat boundary. The symbol levels are encoded with sign=1 for positive, magnitude=0 for the outer levels (±3) and magnitude=1 for the inner levels (±1).

Top module: `quat_serdes`

## Requirements
- R1: A synchronous reset clears txSign, txMag, rxValid and rxFirst to 0 and resets the bit-pair phase, so the first bitEn after reset is the first bit of a quat (quatEn low).
- R2: bitEn pulses for one cycle every CLK_DIV system clocks; quatEn pulses together with every second bitEn, never on its own.
- R3: With the orientation at 1 (sign first), the bit taken at the first bitEn of a quat becomes txSign and the bit taken at the quatEn bit becomes txMag.
- R4: With the orientation at 0 (magnitude first), the first bit of a quat becomes txMag and the second becomes txSign.
- R5: Levels map as (sign,mag) = 10 for +3, 11 for +1, 01 for -1, 00 for -3.
- R6: txSign/txMag change only in the cycle after a quatEn and hold their value for the rest of the quat period.
- R7: rxSign/rxMag are sampled on the quatEn cycle; the two bits of that quat appear on rxBit during the following quat period, each with rxValid high for one cycle, one cycle after each bitEn.
- R8: rxFirst is high together with rxValid on the first bit of each received quat and low on the second.
- R9: A change of cfgSignFirst is sampled at the next quatEn and governs the quat period that follows, for transmit assembly and receive serialization alike.
- R10: rxValid stays low until a first quat has been sampled after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgSignFirst | input | 1 | 1: sign bit first in each pair; 0: magnitude bit first |
| txBit | input | 1 | Serial transmit bit, taken on each bitEn cycle |
| rxSign | input | 1 | Received quat sign bit, taken on the quatEn cycle |
| rxMag | input | 1 | Received quat magnitude bit, taken on the quatEn cycle |
| bitEn | output | 1 | Bit-rate enable strobe |
| quatEn | output | 1 | Quat-rate enable strobe, second bit of each pair |
| txSign | output | 1 | Assembled transmit quat, sign bit |
| txMag | output | 1 | Assembled transmit quat, magnitude bit |
| rxBit | output | 1 | Serial receive bit |
| rxValid | output | 1 | rxBit is valid this cycle |
| rxFirst | output | 1 | rxBit is the first bit of its quat |

## Verification
The strobes are combinational from registered state, so bitEn and quatEn are judged in the same cycle they appear, while every data output is one register behind: the transmit quat is due one cycle after the quatEn that completes it, and each receive bit one cycle after its bitEn. The bench drives inputs on falling edges while a strobe is high and reads the results on the next falling edge, which is exactly one register stage later. Orientation changes are placed both mid-quat and on the boundary cycle, and the expected ordering of the following period is derived from the value present at that boundary.

// File: rtl/quat_pkg.sv
package quat_pkg;
  // Strobes and ordering handed from the controller to the datapath.
  typedef struct packed {
    logic bitStb;     // one bit period elapsed
    logic firstStb;   // bit period carrying the first bit of a quat
    logic quatStb;    // bit period carrying the second bit (quat boundary)
    logic signFirst;  // ordering in force for the current quat period
  } qstrobe_t;
endpackage

// File: rtl/quat_ctrl.sv
module quat_ctrl
  import quat_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     cfgSignFirst,
  output qstrobe_t strb
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] divCnt;
  logic          phase;
  logic          orient;
  logic          tick;

  generate
    if (CLK_DIV == 1) begin : g_fullRate
      assign tick = 1'b1;
    end else begin : g_divided
      assign tick = (divCnt == LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
      phase  <= 1'b0;
      orient <= cfgSignFirst;
    end else begin
      if (tick) divCnt <= '0;
      else      divCnt <= divCnt + 1'b1;
      phase <= phase ^ tick;
      if (tick && phase) orient <= cfgSignFirst;
    end
  end

  always_comb begin
    strb.bitStb    = tick;
    strb.firstStb  = tick & ~phase;
    strb.quatStb   = tick & phase;
    strb.signFirst = orient;
  end

  // R2: a quat boundary is always also a bit strobe
  assert_quat_on_bit_R2: assert property (@(posedge clk) disable iff (rst)
    strb.quatStb |-> strb.bitStb);

  // R2: two quat boundaries are separated by a first-bit strobe
  assert_pair_alternates_R2: assert property (@(posedge clk) disable iff (rst)
    strb.quatStb |=> !strb.quatStb);

  // R9: ordering only moves at a quat boundary
  assert_orient_at_boundary_R9: assert property (@(posedge clk) disable iff (rst)
    !strb.quatStb |=> $stable(orient));

  generate
    if (CLK_DIV > 1) begin : g_spaceChk
      // R2: bit strobes are isolated single-cycle pulses
      assert_bit_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        strb.bitStb |=> !strb.bitStb);
    end
  endgenerate
endmodule

// File: rtl/quat_dpath.sv
module quat_dpath
  import quat_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  qstrobe_t strb,
  input  logic     txBit,
  input  logic     rxSign,
  input  logic     rxMag,
  output logic     txSign,
  output logic     txMag,
  output logic     rxBit,
  output logic     rxValid,
  output logic     rxFirst
);
  logic txHold;
  logic rxSgnQ;
  logic rxMagQ;
  logic rxArmed;

  always_ff @(posedge clk) begin
    if (rst) begin
      txHold  <= 1'b0;
      txSign  <= 1'b0;
      txMag   <= 1'b0;
      rxSgnQ  <= 1'b0;
      rxMagQ  <= 1'b0;
      rxArmed <= 1'b0;
      rxBit   <= 1'b0;
      rxValid <= 1'b0;
      rxFirst <= 1'b0;
    end else begin
      // transmit: collect first bit, complete the quat on the boundary
      if (strb.firstStb) txHold <= txBit;
      if (strb.quatStb) begin
        txSign  <= strb.signFirst ? txHold : txBit;
        txMag   <= strb.signFirst ? txBit  : txHold;
        rxSgnQ  <= rxSign;
        rxMagQ  <= rxMag;
        rxArmed <= 1'b1;
      end
      // receive: emit the stored quat over the following quat period
      if (strb.firstStb) rxBit <= strb.signFirst ? rxSgnQ : rxMagQ;
      if (strb.quatStb)  rxBit <= strb.signFirst ? rxMagQ : rxSgnQ;
      rxValid <= strb.bitStb & rxArmed;
      rxFirst <= strb.firstStb & rxArmed;
    end
  end

  // R6: transmit quat is held between boundaries
  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !strb.quatStb |=> $stable({txSign, txMag}));

  // R8: the first-bit flag only accompanies a valid bit
  assert_first_valid_R8: assert property (@(posedge clk) disable iff (rst)
    rxFirst |-> rxValid);

  // R7: receive bits appear only one cycle after a bit strobe
  assert_valid_after_bit_R7: assert property (@(posedge clk) disable iff (rst)
    !strb.bitStb |=> !rxValid);

  // R10: before any quat is sampled nothing is marked valid
  assert_no_early_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !rxArmed |-> !rxValid);
endmodule

// File: rtl/quat_serdes.sv
module quat_serdes
  import quat_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cfgSignFirst,
  input  logic txBit,
  input  logic rxSign,
  input  logic rxMag,
  output logic bitEn,
  output logic quatEn,
  output logic txSign,
  output logic txMag,
  output logic rxBit,
  output logic rxValid,
  output logic rxFirst
);
  qstrobe_t strb;

  quat_ctrl #(.CLK_DIV(CLK_DIV)) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .cfgSignFirst (cfgSignFirst),
    .strb         (strb)
  );

  quat_dpath dpath_i (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .txBit   (txBit),
    .rxSign  (rxSign),
    .rxMag   (rxMag),
    .txSign  (txSign),
    .txMag   (txMag),
    .rxBit   (rxBit),
    .rxValid (rxValid),
    .rxFirst (rxFirst)
  );

  assign bitEn  = strb.bitStb;
  assign quatEn = strb.quatStb;
endmodule

// File: tb/quat_serdes_tb_top.sv
`timescale 1ns/1ps
module quat_serdes_tb_top;
  localparam int CLK_DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgSignFirst = 1'b1;
  logic txBit = 1'b0;
  logic rxSign = 1'b0;
  logic rxMag = 1'b0;
  logic bitEn, quatEn, txSign, txMag, rxBit, rxValid, rxFirst;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  // bench model state
  logic orientCur;
  logic armed;
  logic prevS, prevM;
  logic lastTxS, lastTxM;

  always #2 clk = ~clk;

  quat_serdes #(.CLK_DIV(CLK_DIV)) dut_i (
    .clk(clk), .rst(rst), .cfgSignFirst(cfgSignFirst), .txBit(txBit),
    .rxSign(rxSign), .rxMag(rxMag), .bitEn(bitEn), .quatEn(quatEn),
    .txSign(txSign), .txMag(txMag), .rxBit(rxBit), .rxValid(rxValid),
    .rxFirst(rxFirst)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitBit();
    while (!bitEn) @(negedge clk);
  endtask

  // R1: reset state
  task automatic doReset(input logic cfg);
    @(negedge clk);
    rst = 1'b1;
    cfgSignFirst = cfg;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    orientCur = cfg; armed = 1'b0; prevS = 1'b0; prevM = 1'b0;
    lastTxS = 1'b0; lastTxM = 1'b0;
    chk("R1 txSign", txSign, 0);
    chk("R1 txMag", txMag, 0);
    chk("R1 rxValid", rxValid, 0);
    chk("R1 rxFirst", rxFirst, 0);
    waitBit();
    chk("R1 first bit is not boundary", quatEn, 0);
  endtask

  // one full quat period: b0/b1 on transmit, (rs,rm) on receive,
  // midCfg applied at the first bit, edgeCfg applied on the boundary cycle
  task automatic doQuat(input logic b0, input logic b1, input logic rs, input logic rm,
                        input logic midCfg, input logic edgeCfg);
    logic e0, e1;
    waitBit();
    chk("R2 first bit no quatEn", quatEn, 0);
    txBit = b0;
    cfgSignFirst = midCfg;
    @(negedge clk);
    e0 = orientCur ? prevS : prevM;
    chk("R10/R7 rxValid first", rxValid, armed);
    chk("R8 rxFirst first", rxFirst, armed);
    if (armed) chk("R7 rxBit first", rxBit, e0);
    chk("R6 txSign held", txSign, lastTxS);
    chk("R6 txMag held", txMag, lastTxM);
    waitBit();
    chk("R2 second bit quatEn", quatEn, 1);
    txBit = b1;
    rxSign = rs; rxMag = rm;
    cfgSignFirst = edgeCfg;
    @(negedge clk);
    lastTxS = orientCur ? b0 : b1;
    lastTxM = orientCur ? b1 : b0;
    chk(orientCur ? "R3 txSign" : "R4 txSign", txSign, lastTxS);
    chk(orientCur ? "R3 txMag" : "R4 txMag", txMag, lastTxM);
    e1 = orientCur ? prevM : prevS;
    chk("R10/R7 rxValid second", rxValid, armed);
    chk("R8 rxFirst second", rxFirst, 0);
    if (armed) chk("R7 rxBit second", rxBit, e1);
    prevS = rs; prevM = rm; armed = 1'b1;
    orientCur = edgeCfg;  // R9: value present at the boundary
  endtask

  task automatic testSpacing();
    int gap;
    int bits;
    int quats;
    waitBit();
    @(negedge clk);
    gap = 1;
    while (!bitEn) begin gap++; @(negedge clk); end
    chk("R2 bitEn period", gap, CLK_DIV);
    bits = 0; quats = 0;
    for (int c = 0; c < 8 * CLK_DIV; c++) begin
      @(negedge clk);
      if (bitEn) bits++;
      if (quatEn) quats++;
      if (quatEn && !bitEn) chk("R2 quatEn without bitEn", 1, 0);
    end
    chk("R2 bits per window", bits, 8);
    chk("R2 quats per window", quats, 4);
  endtask

  task automatic testSignFirst();
    doReset(1'b1);
    doQuat(1, 0, 1, 0, 1, 1);
    doQuat(0, 1, 0, 1, 1, 1);
    doQuat(1, 1, 1, 1, 1, 1);
    doQuat(0, 0, 0, 0, 1, 1);
  endtask

  task automatic testMagFirst();
    doReset(1'b0);
    doQuat(1, 0, 1, 0, 0, 0);
    doQuat(0, 1, 0, 1, 0, 0);
    doQuat(1, 1, 0, 0, 0, 0);
    doQuat(0, 0, 1, 1, 0, 0);
  endtask

  // R5: level encoding in sign-first order
  task automatic testLevels();
    doReset(1'b1);
    doQuat(1, 0, 0, 0, 1, 1);
    chk("R5 +3 is (1,0)", {txSign, txMag}, 2'b10);
    doQuat(1, 1, 0, 0, 1, 1);
    chk("R5 +1 is (1,1)", {txSign, txMag}, 2'b11);
    doQuat(0, 1, 0, 0, 1, 1);
    chk("R5 -1 is (0,1)", {txSign, txMag}, 2'b01);
    doQuat(0, 0, 0, 0, 1, 1);
    chk("R5 -3 is (0,0)", {txSign, txMag}, 2'b00);
  endtask

  // R9: mid-quat change is deferred; boundary change applies next period
  task automatic testOrientSwitch();
    doReset(1'b1);
    doQuat(1, 0, 1, 0, 1, 1);
    doQuat(1, 0, 0, 1, 0, 0);   // switch mid-quat: this quat still sign-first
    chk("R9 mid change deferred", {txSign, txMag}, 2'b10);
    doQuat(1, 0, 1, 1, 0, 1);   // magnitude-first period, flip back at edge
    chk("R9 new order applied", {txSign, txMag}, 2'b01);
    doQuat(0, 1, 1, 0, 1, 1);
    doQuat(1, 1, 0, 1, 1, 0);
    doQuat(0, 1, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    doReset(1'b1);
    testSpacing();
    testSignFirst();
    testMagFirst();
    testLevels();
    testOrientSwitch();
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule